// File: doc/BRIEF.md
# Fully Associative Line Cache

This block keeps a small set of cache lines, each tagged with a full line address, and answers lookups in a single cycle. The tag comparison and the line array work side by side: while the tag store finds the matching way, the line array reads that way and, if asked, overwrites it. Results come out of registers one cycle after the command.

A client drives one command per cycle through four strobes (request, read/write, invalidate, replace) together with a line address and a line of input data. Lookups report hit or miss and return the stored line. They can also overwrite the line, drop it after the access, or both. A replace picks a victim way and installs the new tag and line there. On the following cycle it hands back the victim's old tag and old line, so that the client can write them back. Filling from memory, word selection and write-back ordering are left to the client.

Top module: `assoc_cache`

## Requirements
- R1: An active-low reset clears every valid bit, zeroes every stored tag and drives hit, miss, line output and evicted-address output to zero. The first lookup after reset misses.
- R2: A cycle with request high is a lookup. In the following cycle exactly one of hit and miss is high.
- R3: A cycle with request low raises neither hit nor miss in the following cycle.
- R4: A lookup that hits presents the line stored in the matching way on the line output in the following cycle (read with read/write low and invalidate low, strobe code 1000 in the order request, read/write, invalidate, replace).
- R5: An update (code 1100) that hits stores the line input into the matching way. The line output of the following cycle shows the content held before the write, because the array returns old data on a write.
- R6: A lookup that misses changes no tag, valid bit, line or recency state, and the line output keeps its previous value.
- R7: A lookup with invalidate high that hits (code 1010, or code 1110 which first writes the line input) returns the old line as in R4 and then clears the valid bit of that way, so a later lookup of the same address misses.
- R8: A replace (request low, invalidate low, replace high) picks as victim the lowest-numbered invalid way if one exists, or otherwise the least recently used way. It stores the address and line input there and marks the way valid. In the following cycle the evicted-address output shows the tag that way held and the line output shows the line it held. The client issues a replace only for an address that is not present.
- R9: A lookup hit and a replace both make the accessed way the most recently used. Reset orders recency so that way 0 is the most recent and the highest way the least.
- R10: With request low, any combination other than invalidate low with replace high is idle and changes nothing. With request high the replace strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Lookup strobe |
| rw | input | 1 | On a lookup, write the line input into the hit way |
| inv | input | 1 | On a lookup, drop the hit way afterwards; on a non-lookup cycle, blocks a replace |
| rep | input | 1 | Replace strobe, valid only with req low |
| addr | input | ADDR_W | Line address (no word or byte select bits) |
| line_in | input | DATA_W | Line content to store |
| line_out | output | DATA_W | Line read by the previous command |
| hit | output | 1 | Previous lookup found the address |
| miss | output | 1 | Previous lookup did not find the address |
| old_addr | output | ADDR_W | Tag evicted by the previous replace |

## Verification
The bench builds the cache with four ways, 8-bit addresses and 8-bit lines. With only four ways, a random stream over eight addresses fills the cache quickly and keeps evicting, so replaces of both invalid and least-recently-used victims occur often. Dropped ways also get refilled, and stale data can be returned from a way that was previously invalidated. The narrow address space makes repeated hits on the same way common, which drives the recency order through most of its permutations. A reference model of tags, valid bits, recency ages and line contents predicts every output.

// File: rtl/assoc_cache_pkg.sv
// Shared command type and decoder for the associative line cache.
// Assumes the strobes are already synchronous to the cache clock.
package assoc_cache_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_UPDATE,
        OP_READ_DROP,
        OP_WRITE_DROP,
        OP_REPLACE
    } cache_op_e;

    // Map the four strobes onto one operation; request has precedence.
    function automatic cache_op_e decode_op(input logic req, input logic rw,
                                            input logic inv, input logic rep);
        cache_op_e op;
        if (req) begin
            case ({rw, inv})
                2'b00:   op = OP_READ;
                2'b10:   op = OP_UPDATE;
                2'b01:   op = OP_READ_DROP;
                default: op = OP_WRITE_DROP;
            endcase
        end else if (!inv && rep) begin
            op = OP_REPLACE;
        end else begin
            op = OP_IDLE;
        end
        return op;
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
// Tag and valid store with a parallel compare of every way.
// Assumes at most one valid way holds a given tag (the client never
// replaces in an address that is present). Reads of the victim tag are
// combinational, so a replace sees the tag held before its own write.
module cache_tag_store #(
    parameter int WAYS   = 8,
    parameter int ADDR_W = 8,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_tag,
    output logic [WAYS-1:0]   hit_oh,
    output logic              hit_any,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [WAYS-1:0]   valid_vec,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_tag,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [ADDR_W-1:0] fill_tag,
    input  logic              drop_en,
    input  logic [IDX_W-1:0]  drop_idx
);

    logic [ADDR_W-1:0] tag_q [WAYS];
    logic [WAYS-1:0]   valid_q;

    // Install a tag on fill, clear a valid bit on drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < WAYS; i++) tag_q[i] <= '0;
        end else begin
            for (int i = 0; i < WAYS; i++) begin
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    tag_q[i]   <= fill_tag;
                    valid_q[i] <= 1'b1;
                end else if (drop_en && drop_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    // One comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_oh[g] = valid_q[g] && (tag_q[g] == look_tag);
    end

    // Encode the one-hot match into a way index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_oh[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit_any   = |hit_oh;
    assign valid_vec = valid_q;
    assign rd_tag    = tag_q[rd_idx];

endmodule

// File: rtl/cache_lru.sv
// Recency tracker and victim selector. Each way keeps an age; age 0 is
// the most recent and WAYS-1 the least. The ages always form a
// permutation. The victim is the lowest invalid way, else the oldest way.
module cache_lru #(
    parameter int WAYS   = 8,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAYS-1:0]  valid_vec,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] age_q [WAYS];
    logic [IDX_W-1:0] touch_age;
    logic [IDX_W-1:0] oldest_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    assign touch_age = age_q[touch_idx];

    // Move the touched way to age 0 and age every younger way by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (touch_idx == IDX_W'(i))
                    age_q[i] <= '0;
                else if (age_q[i] < touch_age)
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Find the oldest way and the lowest-numbered invalid way.
    always_comb begin
        oldest_idx = '0;
        free_idx   = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (age_q[i] == IDX_W'(WAYS - 1)) oldest_idx = IDX_W'(i);
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign any_free   = ~&valid_vec;
    assign victim_idx = any_free ? free_idx : oldest_idx;

endmodule

// File: rtl/cache_line_store.sv
// Line array, single port, read-first: an access returns the content
// held before any write in the same cycle. The array has no reset; only
// the output register is cleared.
module cache_line_store #(
    parameter int WAYS   = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] mem_q [WAYS];

    // Write port of the array.
    always_ff @(posedge clk) begin
        if (en && we) mem_q[idx] <= din;
    end

    // Registered read of the old content; holds when not accessed.
    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= '0;
        else if (en) dout <= mem_q[idx];
    end

endmodule

// File: rtl/assoc_cache.sv
// Fully associative line cache with a four-strobe command interface.
// Each command is accepted every cycle; hit, miss, line output and
// evicted tag are registered and appear one cycle later.
// Assumes a replace is only issued for an address not already cached.
module assoc_cache
    import assoc_cache_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rw,
    input  logic              inv,
    input  logic              rep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] line_in,
    output logic [DATA_W-1:0] line_out,
    output logic              hit,
    output logic              miss,
    output logic [ADDR_W-1:0] old_addr
);

    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    cache_op_e         op;
    logic              is_lookup;
    logic              is_repl;
    logic              wants_write;
    logic              wants_drop;
    logic [WAYS-1:0]   hit_oh;
    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx;
    logic [WAYS-1:0]   valid_vec;
    logic [IDX_W-1:0]  victim_idx;
    logic [ADDR_W-1:0] victim_tag;
    logic [IDX_W-1:0]  acc_idx;
    logic              store_en;
    logic              store_we;
    logic              hit_q;
    logic              miss_q;
    logic [ADDR_W-1:0] old_q;

    // Decode the strobes and derive the per-cycle controls.
    always_comb begin
        op          = decode_op(req, rw, inv, rep);
        is_lookup   = (op == OP_READ) || (op == OP_UPDATE) ||
                      (op == OP_READ_DROP) || (op == OP_WRITE_DROP);
        is_repl     = (op == OP_REPLACE);
        wants_write = (op == OP_UPDATE) || (op == OP_WRITE_DROP);
        wants_drop  = (op == OP_READ_DROP) || (op == OP_WRITE_DROP);
        acc_idx     = is_repl ? victim_idx : hit_idx;
        store_en    = (is_lookup && hit_any) || is_repl;
        store_we    = (wants_write && hit_any) || is_repl;
    end

    cache_tag_store #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_tag  (addr),
        .hit_oh    (hit_oh),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .valid_vec (valid_vec),
        .rd_idx    (victim_idx),
        .rd_tag    (victim_tag),
        .fill_en   (is_repl),
        .fill_idx  (victim_idx),
        .fill_tag  (addr),
        .drop_en   (wants_drop && hit_any),
        .drop_idx  (hit_idx)
    );

    cache_lru #(.WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (store_en),
        .touch_idx  (acc_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    cache_line_store #(.WAYS(WAYS), .DATA_W(DATA_W)) u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (store_en),
        .we    (store_we),
        .idx   (acc_idx),
        .din   (line_in),
        .dout  (line_out)
    );

    // Register the lookup outcome and the evicted tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            miss_q <= 1'b0;
            old_q  <= '0;
        end else begin
            hit_q  <= is_lookup && hit_any;
            miss_q <= is_lookup && !hit_any;
            if (is_repl) old_q <= victim_tag;
        end
    end

    assign hit      = hit_q;
    assign miss     = miss_q;
    assign old_addr = old_q;

endmodule

// File: rtl/assoc_cache_chk.sv
// Property checker for the associative line cache, bound to every
// instance of the top module. Observes ports and the way-match vector.
module assoc_cache_chk #(
    parameter int WAYS   = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              hit,
    input logic              miss,
    input logic [DATA_W-1:0] line_out,
    input logic [WAYS-1:0]   hit_oh
);

    // R1: reset leaves hit and miss low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!hit && !miss));

    // R2: hit and miss are never high together.
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    // R2: every lookup is answered one cycle later.
    a_r2_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (hit || miss));

    // R3: no answer without a lookup.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!hit && !miss));

    // R6: a miss leaves the line output alone.
    a_r6_miss_holds_line: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> $stable(line_out));

    // R8: a tag is never held valid in two ways.
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_oh));

endmodule

bind assoc_cache assoc_cache_chk #(.WAYS(WAYS), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .hit      (hit),
    .miss     (miss),
    .line_out (line_out),
    .hit_oh   (hit_oh)
);

// File: tb/sim_assoc_cache.sv
module sim_assoc_cache;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NVEC = 9;

    // Vector: cmd[30:27] addr[26:19] din[18:11] hit[10] miss[9] chk_line[8] line[7:0]
    localparam logic [30:0] VECS [NVEC] = '{
        {4'b1000, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},  // R1 first lookup misses
        {4'b0001, 8'h10, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00},  // R8 install
        {4'b1000, 8'h10, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA1},  // R4 read hit
        {4'b1100, 8'h10, 8'hB2, 1'b1, 1'b0, 1'b1, 8'hA1},  // R5 read-first
        {4'b1000, 8'h10, 8'h00, 1'b1, 1'b0, 1'b1, 8'hB2},  // R5 new content
        {4'b1010, 8'h10, 8'h00, 1'b1, 1'b0, 1'b1, 8'hB2},  // R7 read and drop
        {4'b1000, 8'h10, 8'h00, 1'b0, 1'b1, 1'b1, 8'hB2},  // R7 gone, R6 line held
        {4'b1110, 8'h20, 8'h55, 1'b0, 1'b1, 1'b1, 8'hB2},  // R6 write-drop miss
        {4'b0000, 8'h10, 8'h00, 1'b0, 1'b0, 1'b1, 8'hB2}   // R3 idle
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, rw = 1'b0, inv = 1'b0, rep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] line_in = '0;
    logic [DW-1:0] line_out;
    logic hit, miss;
    logic [AW-1:0] old_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model
    logic [AW-1:0] mtag [W];
    bit            mval [W];
    int            mage [W];
    logic [DW-1:0] mdata [W];
    bit            mknown [W];
    bit exp_hit, exp_miss, exp_chk_old, exp_line_known;
    logic [DW-1:0] exp_line;
    logic [AW-1:0] exp_old;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_cache #(.WAYS(W), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .inv(inv), .rep(rep),
        .addr(addr), .line_in(line_in), .line_out(line_out),
        .hit(hit), .miss(miss), .old_addr(old_addr)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < W; i++) begin
            mtag[i] = '0; mval[i] = 0; mage[i] = i; mknown[i] = 0; mdata[i] = '0;
        end
        exp_line = '0; exp_line_known = 1; exp_hit = 0; exp_miss = 0; exp_chk_old = 0;
        exp_old = '0;
    endtask

    task automatic touch(input int v);
        int av = mage[v];
        for (int j = 0; j < W; j++) begin
            if (j == v) mage[j] = 0;
            else if (mage[j] < av) mage[j]++;
        end
    endtask

    task automatic model_step(input logic [3:0] cmd, input logic [AW-1:0] a,
                              input logic [DW-1:0] d);
        int hw = -1;
        int v = -1;
        exp_hit = 0; exp_miss = 0; exp_chk_old = 0;
        if (cmd[3]) begin
            for (int j = 0; j < W; j++) if (mval[j] && mtag[j] == a) hw = j;
            if (hw >= 0) begin
                exp_hit = 1;
                exp_line = mdata[hw]; exp_line_known = mknown[hw];
                if (cmd[2]) begin mdata[hw] = d; mknown[hw] = 1; end
                if (cmd[1]) mval[hw] = 0;
                touch(hw);
            end else begin
                exp_miss = 1;
            end
        end else if (!cmd[1] && cmd[0]) begin
            for (int j = W - 1; j >= 0; j--) if (!mval[j]) v = j;
            if (v < 0) for (int j = 0; j < W; j++) if (mage[j] == W - 1) v = j;
            exp_old = mtag[v]; exp_chk_old = 1;
            exp_line = mdata[v]; exp_line_known = mknown[v];
            mdata[v] = d; mknown[v] = 1; mtag[v] = a; mval[v] = 1;
            touch(v);
        end
    endtask

    // Drive one command at a falling edge and wait until its results show.
    task automatic do_cmd(input logic [3:0] cmd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
        {req, rw, inv, rep} = cmd;
        addr = a; line_in = d;
        model_step(cmd, a, d);
        @(negedge clk);
    endtask

    task automatic check_model(input string rq);
        check(hit === exp_hit, rq, "hit", 32'(hit), 32'(exp_hit));
        check(miss === exp_miss, rq, "miss", 32'(miss), 32'(exp_miss));
        if (exp_line_known)
            check(line_out === exp_line, rq, "line", 32'(line_out), 32'(exp_line));
        if (exp_chk_old)
            check(old_addr === exp_old, rq, "old_addr", 32'(old_addr), 32'(exp_old));
    endtask

    task automatic do_reset();
        {req, rw, inv, rep} = 4'b0000;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(hit === 1'b0 && miss === 1'b0, "R1", "hit/miss", {hit, miss}, 0);
        check(line_out === '0, "R1", "line", 32'(line_out), 0);
        check(old_addr === '0, "R1", "old_addr", 32'(old_addr), 0);

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            logic [30:0] vv = VECS[k];
            do_cmd(vv[30:27], vv[26:19], vv[18:11]);
            check(hit === vv[10], "R2/R3 table", "hit", 32'(hit), 32'(vv[10]));
            check(miss === vv[9], "R2/R3 table", "miss", 32'(miss), 32'(vv[9]));
            if (vv[8])
                check(line_out === vv[7:0], "R4/R5 table", "line", 32'(line_out), 32'(vv[7:0]));
        end

        // R8/R9 least-recently-used eviction
        do_reset();
        for (int k = 1; k <= 4; k++) do_cmd(4'b0001, AW'(k), DW'(8'hC0 + k));
        do_cmd(4'b1000, 8'd1, 8'h00);
        check(hit === 1'b1 && line_out === 8'hC1, "R4", "hit line", 32'(line_out), 32'hC1);
        do_cmd(4'b0001, 8'd5, 8'hC5);
        check(old_addr === 8'd2, "R9", "evicted tag", 32'(old_addr), 32'd2);
        check(line_out === 8'hC2, "R8", "evicted line", 32'(line_out), 32'hC2);
        do_cmd(4'b1000, 8'd2, 8'h00);
        check(miss === 1'b1, "R8", "evicted miss", 32'(miss), 1);
        do_cmd(4'b1000, 8'd5, 8'h00);
        check(hit === 1'b1 && line_out === 8'hC5, "R8", "new line", 32'(line_out), 32'hC5);

        // R7 write-and-drop on a hit, then replace reuses the freed way
        do_cmd(4'b1110, 8'd3, 8'hEE);
        check(hit === 1'b1 && line_out === 8'hC3, "R7", "drop old line", 32'(line_out), 32'hC3);
        do_cmd(4'b1000, 8'd3, 8'h00);
        check(miss === 1'b1, "R7", "dropped miss", 32'(miss), 1);
        do_cmd(4'b0001, 8'd9, 8'h99);
        check(old_addr === 8'd3 && line_out === 8'hEE, "R8", "invalid victim", 32'(line_out), 32'hEE);

        // R10 encodings that do nothing, and replace bit ignored on lookup
        do_cmd(4'b0011, 8'd7, 8'h77);
        check(hit === 1'b0 && miss === 1'b0, "R10", "0011 idle", {hit, miss}, 0);
        do_cmd(4'b0010, 8'd7, 8'h77);
        do_cmd(4'b1001, 8'd7, 8'h00);
        check(miss === 1'b1, "R10", "no install", 32'(miss), 1);
        do_cmd(4'b1001, 8'd9, 8'h00);
        check(hit === 1'b1 && line_out === 8'h99, "R10", "1001 reads", 32'(line_out), 32'h99);

        // random sequences against the reference model
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] c;
            logic [AW-1:0] a = AW'($urandom_range(0, 7));
            logic [DW-1:0] d = DW'($urandom);
            int sel = $urandom_range(0, 9);
            bit present = 0;
            for (int j = 0; j < W; j++) if (mval[j] && mtag[j] == a) present = 1;
            case (sel)
                0: c = 4'b0000;
                1, 2: c = 4'b1000;
                3: c = 4'b1100;
                4: c = 4'b1010;
                5: c = 4'b1110;
                6: c = 4'b0011;
                default: c = present ? 4'b1000 : 4'b0001;
            endcase
            do_cmd(c, a, d);
            check_model("R2/R4/R8/R9 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule